// File: doc/BRIEF.md
# Wide Burst Link with Relay Stage

This block carries traffic between two upper-level switches over a channel four words wide. On the sending side a packer collects one-word items from a narrow producer into four-word beats, and three such beats form one burst. Once three beats are staged, the link raises a request. When a grant arrives, the link runs a fixed eight-cycle exchange. The destination buffer address goes out for three cycles and is presented at the far end after a relay register. The three beats then stream out while the receiver returns its verdict on an acknowledge line.

The receiver accepts a burst only as a whole. Its acknowledge means "room for all three beats", and it decides this at the moment the address lands. In the last cycle, an accepted burst is appended to the receive queue and cleared from the sender. A refused burst leaves the queue untouched. The sender keeps its beats and asks again, so the same data is sent in a later round. While a finished beat cannot move into staging, the packer stops taking words.

Top module: `wide_burst_link`

## Requirements
- R1: A word is taken when in_valid and in_ready are both high at a clock edge. Four taken words form one beat, with the first word in bits [W-1:0] and each later word in the next W-bit lane up.
- R2: in_ready falls at the edge that takes the fourth word of a beat. It stays low until that beat moves into staging, which happens only while the link is idle and fewer than three beats are staged.
- R3: req is high exactly when three beats are staged and no exchange is running. A cycle with both req and grant high is cycle 1 of an exchange.
- R4: addr_vld is high in cycles 2 to 4, and addr_line then carries the dest_addr value captured in cycle 1. far_addr_vld is high in cycle 5 only, with far_addr carrying that same address after the relay register.
- R5: data_vld is high in cycles 5 to 7, and data_line carries the staged beats oldest first, one per cycle.
- R6: ack_line in cycle 5 is high when at least three receive-queue entries are free in that cycle. Cycles 6 and 7 repeat the cycle-5 value, and ack_line is low at all other times.
- R7: done is high in cycle 8 only, and done_ok in that cycle equals the acknowledge given for the burst.
- R8: After an accepted burst, its three beats are appended in order to the receive queue at the end of cycle 8, and the staging area is empty afterwards.
- R9: A refused burst adds nothing to the queue. The sender keeps the three beats, raises req again in the following cycle, and resends the same beats in its next exchange.
- R10: q_valid is high whenever the queue holds a beat, and q_data is the oldest beat. q_pop removes that beat at the clock edge, and a pop while the queue is empty has no effect.
- R11: During reset in_ready is high, and req, addr_vld, far_addr_vld, data_vld, ack_line, done and q_valid are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_word | input | W | One-word item from the narrow producer |
| in_valid | input | 1 | Narrow item is present |
| in_ready | output | 1 | Packer can take an item |
| grant | input | 1 | Scheduler grant for this link |
| req | output | 1 | Three beats staged, link idle |
| dest_addr | input | AW | Destination buffer address for the next exchange |
| addr_line | output | AW | Address line from the sender |
| addr_vld | output | 1 | Address line active (cycles 2 to 4) |
| far_addr | output | AW | Address as seen at the far switch |
| far_addr_vld | output | 1 | Address arrival at the far switch (cycle 5) |
| data_line | output | 4*W | Wide data line from the sender |
| data_vld | output | 1 | Data line active (cycles 5 to 7) |
| ack_line | output | 1 | Receiver acknowledge, high means room for the burst |
| done | output | 1 | Final cycle of an exchange |
| done_ok | output | 1 | Burst accepted, valid with done |
| q_pop | input | 1 | Remove the oldest beat from the receive queue |
| q_data | output | 4*W | Oldest beat in the receive queue |
| q_valid | output | 1 | Receive queue is not empty |

## Verification
The hardest situation to reach is a refused burst followed by a resend of the same beats. Only a receive queue with fewer than three free entries produces it, so the stimulus first withholds pops while grants flow. Two bursts then fill the queue to six entries, and the third is refused over and over while the packer stalls behind it. Later phases turn pops on at random, so the queue sits near the five-entry boundary and pops land inside cycles 5 to 8. This tests that the verdict taken in cycle 5 is the one that decides the commit.

// File: rtl/wide_burst_link.sv
module wide_burst_link #(
  parameter int W  = 8,
  parameter int AW = 6,
  parameter int QD = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [W-1:0]    in_word,
  input  logic            in_valid,
  output logic            in_ready,
  input  logic            grant,
  output logic            req,
  input  logic [AW-1:0]   dest_addr,
  output logic [AW-1:0]   addr_line,
  output logic            addr_vld,
  output logic [AW-1:0]   far_addr,
  output logic            far_addr_vld,
  output logic [4*W-1:0]  data_line,
  output logic            data_vld,
  output logic            ack_line,
  output logic            done,
  output logic            done_ok,
  input  logic            q_pop,
  output logic [4*W-1:0]  q_data,
  output logic            q_valid
);
  localparam int BW  = 4 * W;
  localparam int NB  = 3;
  localparam int QAW = $clog2(QD);
  localparam logic [QAW:0] ACK_LIM = (QAW+1)'(QD - NB);

  logic [BW-1:0]  pack;
  logic [1:0]     pw;
  logic           pfull;
  logic [BW-1:0]  stage [NB];
  logic [1:0]     scnt;
  logic [3:0]     ph;
  logic [AW-1:0]  dest_q;
  logic           tx_ok;

  logic [AW-1:0]  rly_a;
  logic [BW-1:0]  rly_d;
  logic [BW-1:0]  hold0, hold1;
  logic           ack_q;
  logic [BW-1:0]  qmem [QD];
  logic [QAW-1:0] wp, rp;
  logic [QAW:0]   count;

  logic idle, start, ack_now, commit_rx, pop_ok;

  assign idle      = (ph == 4'd0);
  assign start     = req && grant;
  assign ack_now   = (count <= ACK_LIM);
  assign commit_rx = (ph == 4'd8) && ack_q;
  assign pop_ok    = q_pop && (count != '0);

  assign in_ready     = !pfull;
  assign req          = idle && (scnt == 2'd3);
  assign addr_vld     = (ph >= 4'd2) && (ph <= 4'd4);
  assign addr_line    = dest_q;
  assign far_addr     = rly_a;
  assign far_addr_vld = (ph == 4'd5);
  assign data_vld     = (ph >= 4'd5) && (ph <= 4'd7);
  assign ack_line     = (ph == 4'd5) ? ack_now :
                        ((ph == 4'd6) || (ph == 4'd7)) ? ack_q : 1'b0;
  assign done         = (ph == 4'd8);
  assign done_ok      = tx_ok;
  assign q_valid      = (count != '0);
  assign q_data       = qmem[rp];

  always_comb begin
    case (ph)
      4'd5:    data_line = stage[0];
      4'd6:    data_line = stage[1];
      4'd7:    data_line = stage[2];
      default: data_line = '0;
    endcase
  end

  // sender: packer, staging and exchange sequencing
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pack   <= '0;
      pw     <= '0;
      pfull  <= 1'b0;
      scnt   <= '0;
      ph     <= '0;
      dest_q <= '0;
      tx_ok  <= 1'b0;
      for (int i = 0; i < NB; i++) stage[i] <= '0;
    end else begin
      if (in_valid && !pfull) begin
        pack[32'(pw)*W +: W] <= in_word;
        pw <= pw + 2'd1;
        if (pw == 2'd3) pfull <= 1'b1;
      end
      if (idle && pfull && scnt != 2'd3) begin
        stage[scnt] <= pack;
        scnt  <= scnt + 2'd1;
        pfull <= 1'b0;
      end
      if (start) begin
        ph     <= 4'd2;
        dest_q <= dest_addr;
      end else if (ph == 4'd8) begin
        ph <= 4'd0;
      end else if (ph != 4'd0) begin
        ph <= ph + 4'd1;
      end
      if (ph == 4'd7) tx_ok <= ack_line;
      if (ph == 4'd8 && tx_ok) scnt <= '0;
    end
  end

  // relay stage and receiver
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rly_a <= '0;
      rly_d <= '0;
      hold0 <= '0;
      hold1 <= '0;
      ack_q <= 1'b0;
      wp    <= '0;
      rp    <= '0;
      count <= '0;
    end else begin
      rly_a <= addr_line;
      rly_d <= data_line;
      if (ph == 4'd6) hold0 <= rly_d;
      if (ph == 4'd7) hold1 <= rly_d;
      if (ph == 4'd5) ack_q <= ack_now;
      if (commit_rx) wp <= wp + QAW'(NB);
      if (pop_ok) rp <= rp + QAW'(1);
      count <= count + (commit_rx ? (QAW+1)'(NB) : '0) - {{QAW{1'b0}}, pop_ok};
    end
  end

  always_ff @(posedge clk) begin
    if (commit_rx) begin
      qmem[wp]            <= hold0;
      qmem[wp + QAW'(1)]  <= hold1;
      qmem[wp + QAW'(2)]  <= rly_d;
    end
  end

  // R3
  grant_to_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req && grant) |=> (addr_vld && !req));

  // R4
  addr_lead_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(data_vld) |-> ($past(addr_vld, 1) && $past(addr_vld, 3) && far_addr_vld));

  // R6
  ack_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (data_vld && !far_addr_vld) |-> (ack_line == $past(ack_line)));

  // R7
  verdict_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (done_ok == ack_q));

  // R8
  commit_grow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && done_ok && !pop_ok) |=> (count == $past(count) + (QAW+1)'(NB)));

  // R9
  reject_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !done_ok && !pop_ok) |=> ($stable(count) && req));

  // R10
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    count <= (QAW+1)'(QD));
endmodule

// File: tb/wide_burst_link_tb.sv
module wide_burst_link_tb;
  localparam int CLK_PERIOD = 10;
  localparam int W  = 8;
  localparam int AW = 6;
  localparam int QD = 8;
  localparam int BW = 4 * W;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [W-1:0] in_word = '0;
  logic in_valid = 1'b0, in_ready;
  logic grant = 1'b0, req;
  logic [AW-1:0] dest_addr = '0, addr_line, far_addr;
  logic addr_vld, far_addr_vld, data_vld, ack_line, done, done_ok;
  logic [BW-1:0] data_line, q_data;
  logic q_pop = 1'b0, q_valid;

  wide_burst_link #(.W(W), .AW(AW), .QD(QD)) u_dut (
    .clk(clk), .rst_n(rst_n), .in_word(in_word), .in_valid(in_valid),
    .in_ready(in_ready), .grant(grant), .req(req), .dest_addr(dest_addr),
    .addr_line(addr_line), .addr_vld(addr_vld), .far_addr(far_addr),
    .far_addr_vld(far_addr_vld), .data_line(data_line), .data_vld(data_vld),
    .ack_line(ack_line), .done(done), .done_ok(done_ok), .q_pop(q_pop),
    .q_data(q_data), .q_valid(q_valid));

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0, fails = 0;
  bit finished = 0;
  int feed_pct, grant_pct, pop_pct;

  logic [BW-1:0] m_pack;
  int            m_pw, m_scnt, m_ph;
  bit            m_pfull, m_ack;
  logic [AW-1:0] m_dest;
  logic [BW-1:0] ms [3];
  logic [BW-1:0] mq [$];

  task automatic chk(string rq, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", rq, what, act, exp, $time);
    end
  endtask

  task automatic model_reset();
    m_pack = '0; m_pw = 0; m_scnt = 0; m_ph = 0; m_pfull = 0; m_ack = 0;
    m_dest = '0; mq.delete();
    for (int i = 0; i < 3; i++) ms[i] = '0;
  endtask

  task automatic compare();
    bit exp_ack;
    if (!rst_n) begin
      chk("R11", "in_ready", in_ready, 1);
      chk("R11", "req", req, 0);
      chk("R11", "addr_vld", addr_vld, 0);
      chk("R11", "far_addr_vld", far_addr_vld, 0);
      chk("R11", "data_vld", data_vld, 0);
      chk("R11", "ack_line", ack_line, 0);
      chk("R11", "done", done, 0);
      chk("R11", "q_valid", q_valid, 0);
      return;
    end
    chk("R2", "in_ready", in_ready, !m_pfull);
    chk("R3 R9", "req", req, (m_ph == 0 && m_scnt == 3));
    chk("R4", "addr_vld", addr_vld, (m_ph >= 2 && m_ph <= 4));
    if (m_ph >= 2 && m_ph <= 4) chk("R4", "addr_line", addr_line, m_dest);
    chk("R4", "far_addr_vld", far_addr_vld, (m_ph == 5));
    if (m_ph == 5) chk("R4", "far_addr", far_addr, m_dest);
    chk("R5", "data_vld", data_vld, (m_ph >= 5 && m_ph <= 7));
    if (m_ph >= 5 && m_ph <= 7) chk("R5 R1", "data_line", data_line, ms[m_ph-5]);
    if (m_ph == 5) exp_ack = ((QD - mq.size()) >= 3);
    else if (m_ph == 6 || m_ph == 7) exp_ack = m_ack;
    else exp_ack = 0;
    chk("R6", "ack_line", ack_line, exp_ack);
    chk("R7", "done", done, (m_ph == 8));
    if (m_ph == 8) chk("R7", "done_ok", done_ok, m_ack);
    chk("R10", "q_valid", q_valid, (mq.size() > 0));
    if (mq.size() > 0) chk("R8 R10", "q_data", q_data, mq[0]);
  endtask

  task automatic model_update();
    int ph, scnt, sz;
    bit pf;
    if (!rst_n) begin model_reset(); return; end
    ph = m_ph; scnt = m_scnt; pf = m_pfull; sz = mq.size();
    if (ph == 5) m_ack = ((QD - sz) >= 3);
    if (q_pop && sz > 0) void'(mq.pop_front());
    if (ph == 8 && m_ack) begin
      for (int i = 0; i < 3; i++) mq.push_back(ms[i]);
      m_scnt = 0;
    end
    if (ph == 0 && pf && scnt < 3) begin
      ms[scnt] = m_pack; m_scnt = scnt + 1; m_pfull = 0;
    end
    if (in_valid && !pf) begin
      m_pack[m_pw*W +: W] = in_word;
      m_pw++;
      if (m_pw == 4) begin m_pfull = 1; m_pw = 0; end
    end
    if (ph == 0 && scnt == 3 && grant) begin m_ph = 2; m_dest = dest_addr; end
    else if (ph == 8) m_ph = 0;
    else if (ph != 0) m_ph = ph + 1;
  endtask

  task automatic run(int n);
    for (int c = 0; c < n; c++) begin
      @(negedge clk);
      compare();
      in_valid  = ($urandom_range(99) < feed_pct);
      in_word   = W'($urandom);
      grant     = ($urandom_range(99) < grant_pct);
      q_pop     = ($urandom_range(99) < pop_pct);
      dest_addr = AW'($urandom);
      @(posedge clk);
      model_update();
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    model_reset();
    feed_pct = 0; grant_pct = 0; pop_pct = 0;
    run(3);                                   // R11 reset state
    rst_n = 1'b1;
    feed_pct = 100; grant_pct = 100; pop_pct = 0;
    run(400);                                 // R9 queue fills, bursts refused
    feed_pct = 100; grant_pct = 60; pop_pct = 50;
    run(600);                                 // R6 pops around the cycle-5 verdict
    feed_pct = 70; grant_pct = 50; pop_pct = 30;
    run(1500);                                // R1 R2 R5 R8 mixed traffic
    feed_pct = 0; grant_pct = 100; pop_pct = 100;
    run(200);                                 // R10 drain and pops when empty
    feed_pct = 100; grant_pct = 100; pop_pct = 20;
    run(800);                                 // R3 R4 R7 back-to-back exchanges
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule